// File: doc/BRIEF.md
# Comparator-Feedback PWM Analog-to-Digital Controller

This block is the digital half of a charge-balancing converter. An external resistor-capacitor network is driven from one output pin, and an external comparator compares the capacitor voltage with the unknown input. The block closes the loop. Once in every sample period it reads the comparator. If the capacitor sits below the input, it drives the node high for the next period. If the capacitor sits above the input, it drives the node low. Over a fixed window the share of high periods equals the input as a fraction of the reference.

A conversion is started by a one-cycle request and runs as two passes of equal length. The first pass only pulls the capacitor to the input voltage. The second pass is the measurement. At the start of each pass the block loads two down-counters with all ones: one counts every sample, the other counts only the samples driven low. After the second pass the low counter holds the number of high samples, and that value becomes the result. Between passes, and once the conversion is over, the drive pin is released (output enable low, data low). This keeps the capacitor from drifting while the block is not measuring.

Sample period length and counter width are parameters. Widening the counter trades conversion time for resolution. Widths of 9 to 10 bits are the useful ceiling for such a network.

Top module: `cfb_pwm_adc`

## Requirements
- R1: While reset is asserted and in the first cycle after it, drv_en and drv_level are 0, done is 0 and result is 0.
- R2: The comparator input passes through two flops before use. At each sample decision the drive level is set to the synchronized comparator bit: 1 drives high, 0 drives low. The level is held for the whole sample period.
- R3: Every sample period lasts exactly CLK_PER_SAMPLE clock cycles, whether the level is high or low. The drive level changes only at the first cycle of a period.
- R4: A pass holds 2^CNT_W-1 sample decisions, and a conversion is two passes. If start is sampled at clock edge E0, the first decision falls at E0+1. The measurement pass's first decision falls at E0+P·N+2, where P is CLK_PER_SAMPLE and N is 2^CNT_W-1. done is high in the cycle after edge E0+2·P·N+1.
- R5: After edge E0+P·N, and after the final pass, drv_en and drv_level are both 0. After edge E0 and edge E0+P·N+1, both are 1. While drv_en is 0, drv_level is 0.
- R6: Both counters load all ones at each pass start. The low counter decrements on each low decision and saturates at zero. The result is the low counter after the measurement pass, which equals the count of high decisions in that pass. Precharge-pass decisions do not affect it.
- R7: done is high for exactly one cycle, in the cycle in which result shows a new value. Result otherwise holds its value.
- R8: A start request that arrives during a conversion, including the gap between passes, is ignored. The running conversion keeps its timing and produces a single done pulse.
- R9: With a first-order RC network in the loop, the result equals (2^CNT_W-1)·Vin/Vref within ±4 codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request, honoured only when idle |
| cmp_in | input | 1 | Comparator output, 1 = capacitor below input |
| drv_level | output | 1 | Data level for the RC drive pin |
| drv_en | output | 1 | Output enable of the RC drive pin, 0 = high impedance |
| result | output | CNT_W | Last conversion result |
| done | output | 1 | One-cycle pulse when result updates |

## Verification
Every timed result is counted from the clock edge that samples start. The drive releases at offset P·N and comes back high one cycle later. done and the new result appear only at offset 2·P·N+1. A comparator change needs two cycles through the synchronizer before it reaches a decision. The bench therefore samples outputs on the falling edge at those exact offsets. It changes the comparator ten cycles ahead of each decision, so the two-flop delay never blurs which sample a value belongs to. Expected counts come from the stimulus pattern, or from a real-valued RC model driven by the pins.

// File: rtl/cfb_pwm_adc_pkg.sv
package cfb_pwm_adc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_GAP  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic en;
        logic level;
    } rc_drive_t;

    localparam rc_drive_t DRIVE_OFF  = '{en: 1'b0, level: 1'b0};
    localparam rc_drive_t DRIVE_HIGH = '{en: 1'b1, level: 1'b1};

    function automatic int phase_width(input int period);
        return (period > 1) ? $clog2(period) : 1;
    endfunction

endpackage

// File: rtl/cfb_pwm_adc_sync.sv
module cfb_pwm_adc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cfb_pwm_adc_timer.sv
module cfb_pwm_adc_timer #(
    parameter int PERIOD = 20,
    parameter int PH_W   = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    output logic            first,
    output logic            last,
    output logic [PH_W-1:0] phase
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);

    always_ff @(posedge clk) begin
        if (rst || !run)          phase <= '0;
        else if (phase == PH_LAST) phase <= '0;
        else                       phase <= phase + 1'b1;
    end

    assign first = run && (phase == '0);
    assign last  = run && (phase == PH_LAST);

    // R3: the phase never leaves the period
    a_r3_phase_bound: assert property (@(posedge clk) disable iff (rst)
        phase <= PH_LAST);
endmodule

// File: rtl/cfb_pwm_adc_counters.sv
module cfb_pwm_adc_counters #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic             step_low,
    output logic [CNT_W-1:0] low_cnt,
    output logic             tot_zero
);
    localparam logic [CNT_W-1:0] FULL = '1;

    logic [CNT_W-1:0] tot_cnt;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            tot_cnt <= FULL;
            low_cnt <= FULL;
        end else if (step) begin
            if (tot_cnt != '0)
                tot_cnt <= tot_cnt - 1'b1;
            if (step_low && (low_cnt != '0))
                low_cnt <= low_cnt - 1'b1;
        end
    end

    assign tot_zero = (tot_cnt == '0);

    // R6: low counter holds at zero until the next load
    a_r6_low_saturates: assert property (@(posedge clk) disable iff (rst)
        (!load && low_cnt == '0) |=> low_cnt == '0);

    // R6: low decrements never outrun sample decrements
    a_r6_low_ge_total: assert property (@(posedge clk) disable iff (rst)
        low_cnt >= tot_cnt);
endmodule

// File: rtl/cfb_pwm_adc.sv
module cfb_pwm_adc
    import cfb_pwm_adc_pkg::*;
#(
    parameter int CLK_PER_SAMPLE = 20,
    parameter int CNT_W          = 8,
    parameter int SYNC_STAGES    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cmp_in,
    output logic             drv_level,
    output logic             drv_en,
    output logic [CNT_W-1:0] result,
    output logic             done
);
    localparam int PH_W = phase_width(CLK_PER_SAMPLE);

    seq_state_e       state;
    logic             meas_pass;
    rc_drive_t        drv;
    logic [CNT_W-1:0] result_q;
    logic             done_q;

    logic             cmp_s;
    logic             run;
    logic             ph_first;
    logic             ph_last;
    logic [PH_W-1:0]  phase;
    logic             load;
    logic [CNT_W-1:0] low_cnt;
    logic             tot_zero;
    logic             pass_end;

    cfb_pwm_adc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (cmp_in),
        .q   (cmp_s)
    );

    assign run = (state == ST_RUN);

    cfb_pwm_adc_timer #(.PERIOD(CLK_PER_SAMPLE), .PH_W(PH_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .first (ph_first),
        .last  (ph_last),
        .phase (phase)
    );

    assign load = ((state == ST_IDLE) && start) || (state == ST_GAP);

    cfb_pwm_adc_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .step     (ph_first),
        .step_low (ph_first && !cmp_s),
        .low_cnt  (low_cnt),
        .tot_zero (tot_zero)
    );

    assign pass_end = ph_last && tot_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            meas_pass <= 1'b0;
            drv       <= DRIVE_OFF;
            result_q  <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state     <= ST_RUN;
                        meas_pass <= 1'b0;
                        drv       <= DRIVE_HIGH;
                    end
                end
                ST_RUN: begin
                    if (ph_first)
                        drv.level <= cmp_s;
                    if (pass_end) begin
                        drv <= DRIVE_OFF;
                        if (meas_pass) begin
                            state    <= ST_IDLE;
                            result_q <= low_cnt;
                            done_q   <= 1'b1;
                        end else begin
                            state <= ST_GAP;
                        end
                    end
                end
                ST_GAP: begin
                    state     <= ST_RUN;
                    meas_pass <= 1'b1;
                    drv       <= DRIVE_HIGH;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign drv_level = drv.level;
    assign drv_en    = drv.en;
    assign result    = result_q;
    assign done      = done_q;

    // R3: level frozen inside a sample period
    a_r3_drive_held: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && int'(phase) >= 2) |-> $stable(drv.level));

    // R5: a released pin carries a low data level
    a_r5_off_is_low: assert property (@(posedge clk) disable iff (rst)
        !drv.en |-> !drv.level);

    // R5: the gap between passes keeps the pin released
    a_r5_gap_released: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GAP) |-> !drv.en);

    // R7: done lasts a single cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R7: result moves only together with done
    a_r7_result_holds: assert property (@(posedge clk) disable iff (rst)
        !done_q |-> $stable(result_q));
endmodule

// File: tb/cfb_pwm_adc_tb_top.sv
module cfb_pwm_adc_tb_top;
    localparam int P        = 20;
    localparam int W        = 8;
    localparam int N        = (1 << W) - 1;
    localparam int PASS     = P * N;
    localparam int DONE_M   = 2 * PASS + 1;
    localparam int DEC1     = PASS + 2;
    localparam real TAU     = 2000.0;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         cmp_in = 1'b0;
    logic         drv_level;
    logic         drv_en;
    logic [W-1:0] result;
    logic         done;

    int  n_tests = 0;
    int  n_fail  = 0;
    real cap     = 0.0;

    always #2 clk = ~clk;

    cfb_pwm_adc #(.CLK_PER_SAMPLE(P), .CNT_W(W), .SYNC_STAGES(2)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cmp_in    (cmp_in),
        .drv_level (drv_level),
        .drv_en    (drv_en),
        .result    (result),
        .done      (done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // after return: at the falling edge right after the start edge (m = 0)
    task automatic kick();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(drv_en == 0 && drv_level == 0, "R1 drive in reset", {drv_en, drv_level}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 0, "R1 done after reset", done, 0);
        chk(result == 0, "R1 result after reset", result, 0);
        chk(drv_en == 0 && drv_level == 0, "R1 drive after reset", {drv_en, drv_level}, 0);
    endtask

    task automatic t_const(input logic lvl, input int exp);
        cmp_in = lvl;
        repeat (5) @(negedge clk);
        kick();
        chk(drv_en == 1 && drv_level == 1, "R5 drive high at first pass start", {drv_en, drv_level}, 3);
        repeat (50) @(negedge clk);
        chk(drv_level == lvl, "R2 drive follows comparator", drv_level, lvl);
        repeat (PASS - 50) @(negedge clk);
        chk(drv_en == 0 && drv_level == 0, "R5 released between passes", {drv_en, drv_level}, 0);
        @(negedge clk);
        chk(drv_en == 1 && drv_level == 1, "R5 high at measurement start", {drv_en, drv_level}, 3);
        repeat (DONE_M - PASS - 2) @(negedge clk);
        chk(done == 0, "R4 done not early", done, 0);
        @(negedge clk);
        chk(done == 1, "R4 done at offset", done, 1);
        chk(result == exp, "R6 result for constant comparator", result, exp);
        @(negedge clk);
        chk(done == 0 && result == exp, "R7 single done pulse, result held", {done, result}, exp);
        chk(drv_en == 0 && drv_level == 0, "R5 released after conversion", {drv_en, drv_level}, 0);
    endtask

    function automatic logic pat(input int k);
        return (k % 3 == 0) ? 1'b0 : 1'b1;
    endfunction

    // precharge pass all low, measurement pass low on every third decision
    task automatic t_pattern();
        int errs = 0;
        int bad_k = -1;
        cmp_in = 1'b0;
        repeat (5) @(negedge clk);
        kick();
        for (int m = 1; m <= DONE_M + 1; m++) begin
            @(negedge clk);
            if (m >= DEC1 - 10 && (m - (DEC1 - 10)) % P == 0 && (m - (DEC1 - 10)) / P < N)
                cmp_in = pat((m - (DEC1 - 10)) / P);
            if (m >= DEC1 + 5 && (m - (DEC1 + 5)) % P == 0 && (m - (DEC1 + 5)) / P < N) begin
                if (drv_level !== pat((m - (DEC1 + 5)) / P)) begin
                    errs++;
                    bad_k = (m - (DEC1 + 5)) / P;
                end
            end
            if (m == DONE_M) begin
                chk(done == 1, "R4 done in pattern run", done, 1);
                chk(result == 170, "R6 only measurement pass counts", result, 170);
            end
        end
        chk(errs == 0, "R2 R3 per-period level tracks pattern", bad_k, -1);
    endtask

    task automatic t_busy();
        int pulses = 0;
        int first_m = -1;
        int en_seen = 0;
        cmp_in = 1'b1;
        repeat (5) @(negedge clk);
        kick();
        for (int m = 1; m <= DONE_M + 200; m++) begin
            @(negedge clk);
            if (done) begin
                pulses++;
                if (first_m < 0) first_m = m;
            end
            if (m > DONE_M && drv_en) en_seen++;
            start = (m == 3000 || m == PASS || m == DONE_M - 5);
        end
        start = 1'b0;
        chk(pulses == 1, "R8 one done despite extra starts", pulses, 1);
        chk(first_m == DONE_M, "R8 timing kept", first_m, DONE_M);
        chk(en_seen == 0, "R8 no restart after conversion", en_seen, 0);
        chk(result == 255, "R8 result unaffected", result, 255);
    endtask

    task automatic t_loop(input real vin, input int exp);
        int got = -1;
        cmp_in = (cap < vin);
        kick();
        for (int m = 1; m <= DONE_M + 1; m++) begin
            @(negedge clk);
            if (drv_en) cap = cap + ((drv_level ? 1.0 : 0.0) - cap) / TAU;
            cmp_in = (cap < vin);
            if (m == DONE_M) got = int'(result);
        end
        chk(got >= exp - 4 && got <= exp + 4, "R9 closed-loop result", got, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_const(1'b1, 255);
        t_const(1'b0, 0);
        t_pattern();
        t_busy();
        t_loop(0.30, 77);
        t_loop(0.75, 191);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule